// File: doc/BRIEF.md
# E1 Line All-Ones and Carrier-Loss Detector

This block watches the raw received bit stream of an E1 line, one bit per cycle in which a valid strobe is high. It raises two alarms. The first says the line carries an unframed all-ones pattern. The second says the carrier is lost, which means the line has been silent (all zeros) for too long.

The all-ones detector cuts the stream into back-to-back, non-overlapping windows of 512 valid bits, which is two E1 frames. It counts the zeros in each window and updates its alarm at the end of the window. The carrier-loss detector counts consecutive zeros. A select input sets the zero-run threshold to either a short or a long value. Once carrier loss is declared, the detector runs back-to-back 255-bit windows. It releases the alarm only at the end of a window that held enough ones.

Top module: `e1_line_alarm_det`

## Requirements
- R1: After reset both `all_ones_alarm` and `carrier_loss` are 0, and the first all-ones window begins with the first valid bit.
- R2: At the end of each 512-valid-bit window, if the window held fewer than three zero bits, `all_ones_alarm` is 1 from the cycle after the window's last bit is taken.
- R3: At the end of each 512-valid-bit window, if the window held three or more zero bits, `all_ones_alarm` is 0 from the cycle after the window's last bit is taken. Between window ends the alarm holds its value.
- R4: With `los_thr_long` = 0, `carrier_loss` becomes 1 in the cycle after the 255th consecutive valid zero bit. After only 254 zeros it is still 0.
- R5: With `los_thr_long` = 1, the threshold is 2048 consecutive zeros. After 2047 zeros `carrier_loss` is still 0.
- R6: Any valid 1 bit restarts the consecutive-zero count from zero.
- R7: While `carrier_loss` is 1, valid bits are grouped into back-to-back 255-bit windows. The first window starts with the first valid bit after the alarm rises. At the end of a window that held 32 or more ones, the alarm clears in the next cycle. If the window held fewer ones, the alarm stays set and a new window begins.
- R8: A cycle with `rx_vld` = 0 consumes no bit. It changes neither alarm, any count, nor any window position, whatever `rx_bit` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_vld | input | 1 | High when `rx_bit` carries a received bit |
| rx_bit | input | 1 | Received line bit |
| los_thr_long | input | 1 | 0: 255-zero carrier-loss threshold, 1: 2048-zero threshold |
| all_ones_alarm | output | 1 | Unframed all-ones alarm |
| carrier_loss | output | 1 | Receive carrier-loss alarm |

## Verification
The bench builds the block with its default parameters: 512-bit all-ones windows, thresholds of 255 and 2048 zeros, and a 255-bit clear window needing 32 ones. With these values every boundary is reached in a short run. This covers two versus three zeros in a window, 254 versus 255 and 2047 versus 2048 consecutive zeros, and 31 versus 32 ones in a clear window. Random segments with zero densities from none to all, gaps in the valid strobe, and threshold changes reach the mixed orderings between the two detectors.

// File: rtl/e1_line_alarm_pkg.sv
package e1_line_alarm_pkg;
   // Default dimensions of the line alarm detectors
   localparam int unsigned AO_WIN_BITS   = 512;
   localparam int unsigned AO_MAX_ZEROS  = 2;
   localparam int unsigned LOS_RUN_SHORT = 255;
   localparam int unsigned LOS_RUN_LONG  = 2048;
   localparam int unsigned LOS_CLR_WIN   = 255;
   localparam int unsigned LOS_CLR_ONES  = 32;

   typedef enum logic {
      LOS_THR_SHORT = 1'b0,
      LOS_THR_LONG  = 1'b1
   } los_thr_e;
endpackage

// File: rtl/e1la_ones_window.sv
module e1la_ones_window #(
   parameter int unsigned WIN_BITS  = 512,
   parameter int unsigned MAX_ZEROS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic bit_val,
   output logic alarm
);
   localparam int unsigned PW = $clog2(WIN_BITS);
   localparam int unsigned ZW = $clog2(MAX_ZEROS + 2);

   logic [PW-1:0] pos_q;
   logic [ZW-1:0] zeros_q;
   logic [ZW-1:0] zeros_nxt;

   // zero count saturates one above the tolerated maximum
   always_comb begin
      zeros_nxt = zeros_q;
      if (!bit_val && (zeros_q <= ZW'(MAX_ZEROS)))
         zeros_nxt = zeros_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q   <= '0;
         zeros_q <= '0;
         alarm   <= 1'b0;
      end else if (bit_vld) begin
         if (pos_q == PW'(WIN_BITS - 1)) begin
            pos_q   <= '0;
            zeros_q <= '0;
            alarm   <= (zeros_nxt <= ZW'(MAX_ZEROS));
         end else begin
            pos_q   <= pos_q + 1'b1;
            zeros_q <= zeros_nxt;
         end
      end
   end
endmodule

// File: rtl/e1la_carrier_loss.sv
module e1la_carrier_loss
   import e1_line_alarm_pkg::*;
#(
   parameter int unsigned RUN_SHORT = 255,
   parameter int unsigned RUN_LONG  = 2048,
   parameter int unsigned CLR_WIN   = 255,
   parameter int unsigned CLR_ONES  = 32
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     bit_vld,
   input  logic     bit_val,
   input  los_thr_e thr_mode,
   output logic     loss
);
   localparam int unsigned RW = $clog2(RUN_LONG + 1);
   localparam int unsigned WW = $clog2(CLR_WIN);
   localparam int unsigned OW = $clog2(CLR_ONES + 1);

   logic [RW-1:0] thr;
   logic [RW-1:0] run_q;
   logic [RW:0]   run_inc;
   logic [WW-1:0] wpos_q;
   logic [OW-1:0] ones_q;
   logic [OW-1:0] ones_nxt;

   generate
      if (RUN_SHORT == RUN_LONG) begin : g_fixed_thr
         assign thr = RW'(RUN_LONG);
      end else begin : g_sel_thr
         assign thr = (thr_mode == LOS_THR_LONG) ? RW'(RUN_LONG) : RW'(RUN_SHORT);
      end
   endgenerate

   assign run_inc = {1'b0, run_q} + 1'b1;

   always_comb begin
      ones_nxt = ones_q;
      if (bit_val && (ones_q < OW'(CLR_ONES)))
         ones_nxt = ones_q + 1'b1;
   end

   // consecutive-zero run, saturating at the active threshold
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (bit_vld) begin
         if (bit_val)
            run_q <= '0;
         else if (run_q < thr)
            run_q <= run_q + 1'b1;
      end
   end

   // alarm state and back-to-back clear windows
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loss   <= 1'b0;
         wpos_q <= '0;
         ones_q <= '0;
      end else if (bit_vld) begin
         if (!loss) begin
            wpos_q <= '0;
            ones_q <= '0;
            if (!bit_val && (run_inc >= {1'b0, thr}))
               loss <= 1'b1;
         end else if (wpos_q == WW'(CLR_WIN - 1)) begin
            wpos_q <= '0;
            ones_q <= '0;
            if (ones_nxt >= OW'(CLR_ONES))
               loss <= 1'b0;
         end else begin
            wpos_q <= wpos_q + 1'b1;
            ones_q <= ones_nxt;
         end
      end
   end
endmodule

// File: rtl/e1_line_alarm_det.sv
module e1_line_alarm_det
   import e1_line_alarm_pkg::*;
#(
   parameter int unsigned AO_WIN    = AO_WIN_BITS,
   parameter int unsigned AO_ZMAX   = AO_MAX_ZEROS,
   parameter int unsigned THR_SHORT = LOS_RUN_SHORT,
   parameter int unsigned THR_LONG  = LOS_RUN_LONG,
   parameter int unsigned CLR_WIN   = LOS_CLR_WIN,
   parameter int unsigned CLR_ONES  = LOS_CLR_ONES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_vld,
   input  logic rx_bit,
   input  logic los_thr_long,
   output logic all_ones_alarm,
   output logic carrier_loss
);
   generate
      if (AO_WIN < 4 || AO_ZMAX >= AO_WIN) begin : g_bad_ao
         $error("all-ones window must exceed its zero tolerance");
      end
      if (THR_SHORT < 1 || THR_LONG < THR_SHORT) begin : g_bad_thr
         $error("long threshold must not be below the short one");
      end
      if (CLR_WIN < 2 || CLR_ONES > CLR_WIN) begin : g_bad_clr
         $error("clear window must hold the required ones");
      end
   endgenerate

   los_thr_e thr_mode;
   assign thr_mode = los_thr_long ? LOS_THR_LONG : LOS_THR_SHORT;

   e1la_ones_window #(
      .WIN_BITS  (AO_WIN),
      .MAX_ZEROS (AO_ZMAX)
   ) u_ones (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_vld (rx_vld),
      .bit_val (rx_bit),
      .alarm   (all_ones_alarm)
   );

   e1la_carrier_loss #(
      .RUN_SHORT (THR_SHORT),
      .RUN_LONG  (THR_LONG),
      .CLR_WIN   (CLR_WIN),
      .CLR_ONES  (CLR_ONES)
   ) u_los (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_vld  (rx_vld),
      .bit_val  (rx_bit),
      .thr_mode (thr_mode),
      .loss     (carrier_loss)
   );
endmodule

// File: rtl/e1_line_alarm_chk.sv
module e1_line_alarm_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_vld,
   input logic rx_bit,
   input logic los_thr_long,
   input logic all_ones_alarm,
   input logic carrier_loss
);
   logic unused_sel;
   assign unused_sel = los_thr_long;

   AST_AO_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_vld |=> $stable(all_ones_alarm)); // R8
   AST_LOS_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_vld |=> $stable(carrier_loss)); // R8
   AST_LOS_RISE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carrier_loss) |-> $past(rx_vld && !rx_bit)); // R4
   AST_LOS_FALL_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(carrier_loss) |-> $past(rx_vld)); // R7
   AST_AO_RISE_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(all_ones_alarm) |-> $past(rx_vld)); // R2
   AST_AO_FALL_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(all_ones_alarm) |-> $past(rx_vld)); // R3
endmodule

bind e1_line_alarm_det e1_line_alarm_chk u_chk (.*);

// File: tb/e1_line_alarm_det_test.sv
module e1_line_alarm_det_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_vld = 1'b0;
   logic rx_bit = 1'b0;
   logic los_thr_long = 1'b0;
   logic all_ones_alarm;
   logic carrier_loss;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   // reference state derived from the requirements
   int  m_pos, m_zeros, m_run, m_wpos, m_ones;
   bit  m_ao, m_los;

   always #5 clk = ~clk;

   e1_line_alarm_det uut (.*);

   task automatic chk(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic void model_step(bit b);
      int thr;
      thr = los_thr_long ? 2048 : 255;
      // all-ones windows
      if (!b) m_zeros++;
      if (m_pos == 511) begin
         m_ao = (m_zeros < 3);
         m_pos = 0;
         m_zeros = 0;
      end else m_pos++;
      // carrier loss
      if (b) m_run = 0; else m_run++;
      if (!m_los) begin
         if (!b && m_run >= thr) begin
            m_los = 1'b1;
            m_wpos = 0;
            m_ones = 0;
         end
      end else begin
         if (b) m_ones++;
         if (m_wpos == 254) begin
            if (m_ones >= 32) m_los = 1'b0;
            m_wpos = 0;
            m_ones = 0;
         end else m_wpos++;
      end
   endfunction

   task automatic step(bit v, bit b);
      @(negedge clk);
      rx_vld = v;
      rx_bit = b;
      @(posedge clk);
      #2;
      if (v) model_step(b);
      chk("R2 R3 window", all_ones_alarm, m_ao);
      chk("R4 R5 R6 R7 loss", carrier_loss, m_los);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      rx_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_pos = 0; m_zeros = 0; m_run = 0; m_wpos = 0; m_ones = 0;
      m_ao = 1'b0; m_los = 1'b0;
   endtask

   task automatic bits(int n, bit b);
      for (int i = 0; i < n; i++) step(1'b1, b);
   endtask

   initial begin
      void'($urandom(32'd5150));
      do_reset();
      #1;
      chk("R1 reset ao", all_ones_alarm, 1'b0);
      chk("R1 reset los", carrier_loss, 1'b0);

      // R2: two zeros in a window -> alarm
      bits(100, 1'b1); bits(1, 1'b0); bits(300, 1'b1); bits(1, 1'b0); bits(109, 1'b1);
      chk("R2 before window end", all_ones_alarm, 1'b0);
      bits(1, 1'b1);
      chk("R2 two zeros sets", all_ones_alarm, 1'b1);
      // R3: three zeros -> clear, only at window end
      bits(3, 1'b0); bits(508, 1'b1);
      chk("R3 held mid window", all_ones_alarm, 1'b1);
      bits(1, 1'b1);
      chk("R3 three zeros clears", all_ones_alarm, 1'b0);
      // R8: idle cycles with zeros on the data line
      bits(512, 1'b1);
      chk("R2 all ones sets", all_ones_alarm, 1'b1);
      for (int i = 0; i < 600; i++) step(1'b0, 1'b0);
      chk("R8 idle keeps ao", all_ones_alarm, 1'b1);
      chk("R8 idle keeps los", carrier_loss, 1'b0);
      bits(512, 1'b1);
      chk("R8 window position kept", all_ones_alarm, 1'b1);

      // R4: short threshold boundary
      do_reset();
      los_thr_long = 1'b0;
      bits(254, 1'b0);
      chk("R4 254 zeros", carrier_loss, 1'b0);
      bits(1, 1'b0);
      chk("R4 255 zeros", carrier_loss, 1'b1);

      // R6: a one restarts the run
      do_reset();
      bits(200, 1'b0); bits(1, 1'b1); bits(200, 1'b0);
      chk("R6 run restarted", carrier_loss, 1'b0);
      bits(55, 1'b0);
      chk("R6 fresh run reaches", carrier_loss, 1'b1);

      // R7: 31 ones keep the alarm, 32 ones clear it
      for (int i = 0; i < 255; i++) step(1'b1, (i % 8 == 0) && (i < 248));
      chk("R7 31 ones hold", carrier_loss, 1'b1);
      bits(222, 1'b0); bits(32, 1'b1);
      chk("R7 before window end", carrier_loss, 1'b1);
      bits(1, 1'b0);
      chk("R7 32 ones clear", carrier_loss, 1'b0);

      // R5: long threshold boundary
      do_reset();
      los_thr_long = 1'b1;
      bits(2047, 1'b0);
      chk("R5 2047 zeros", carrier_loss, 1'b0);
      bits(1, 1'b0);
      chk("R5 2048 zeros", carrier_loss, 1'b1);

      // constrained random segments
      do_reset();
      for (int s = 0; s < 40; s++) begin
         int zp;
         case ($urandom_range(0, 4))
            0: zp = 0;
            1: zp = 1;
            2: zp = 50;
            3: zp = 99;
            default: zp = 100;
         endcase
         los_thr_long = 1'($urandom_range(0, 1));
         for (int i = 0; i < 2000; i++)
            step($urandom_range(0, 9) != 0, $urandom_range(0, 99) >= zp);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #1900000;
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule